// File: doc/BRIEF.md
# Precharged-Bus Memory Slave

A small word-addressed memory that sits on a shared parallel bus whose lines are held high by precharge and can only be pulled low by an agent. The bus has three groups of lines: data, address and command. The command group is two separate active-low lines, one for read and one for write. Both lines high means idle.

The block takes the pull-low enables of all other bus agents as one vector. It resolves every bus line as a wired-AND of the released/pulled state of each agent. While the precharge phase input is high, every line reads high. On each rising clock edge in the evaluate phase (precharge low), the slave senses the command and address lines:
- On a write it stores the sensed data lines into the addressed word.
- On a read it latches the read state and address. From the following cycle on, and only during evaluate phases, it pulls low each data line whose stored bit is 0 and releases each line whose stored bit is 1.

The sensed state is held through precharge cycles. The output changes only when the read state or the read address changes, or when the word being read is written.

Top module: `pbus_mem_slave`

## Requirements
- R1: After reset every word holds 0, no read is latched and `mem_pull` is 0.
- R2: While `precharge` is 1, every bit of `bus_level` is 1, whatever any agent pulls.
- R3: While `precharge` is 0, each bus line is 0 exactly when some agent pulls it: `bus_level[i] = ~(master_pull[i] | slave_pull[i])`. The slave's pull is `mem_pull` on the data lines `[DATA_W-1:0]` and 0 on all other lines.
- R4: At a rising edge with `precharge` 0, the slave senses three things from `bus_level`:
  - the read line at bit `DATA_W+ADDR_W` (bit 10), active low;
  - the write line at bit `DATA_W+ADDR_W+1` (bit 11), active low;
  - the address field at bits `[DATA_W+ADDR_W-1:DATA_W]` (bits 9:8).
- R5: At such an edge with the write line low, the sensed data lines `bus_level[DATA_W-1:0]` are stored into the addressed word. A later read of that address returns them.
- R6: In a cycle with `precharge` 0 that follows an edge which sensed a read, `mem_pull` is the bitwise inverse of the word at the latched address. This includes a word updated by a write at that edge.
- R7: `mem_pull` is 0 whenever `precharge` is 1. The slave never pulls an address or command line.
- R8: Edges with `precharge` 1 ignore the bus: the latched read state, the latched address and the contents are all unchanged.
- R9: An edge that senses both command lines high stores nothing. In the following evaluate cycles it leaves `mem_pull` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; sensing and storage on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| precharge | input | 1 | 1 = precharge phase (all lines high), 0 = evaluate phase |
| master_pull | input | 12 | Combined pull-low enables of all other agents, one per bus line |
| bus_level | output | 12 | Resolved level of every bus line |
| mem_pull | output | 8 | Slave's pull-low enables for the data lines |

## Verification
Bus resolution (R2, R3, R7) is combinational and is checked in the same cycle in which the pulls are applied. Commands, writes and address sensing act at the next rising edge. The read pull therefore appears one cycle after the cycle whose bus carried the read command, and only if that later cycle is an evaluate phase. The bench drives inputs just after each falling edge and compares both outputs halfway through the low clock phase. It then advances its own mirror of the contents and of the latched read state with what the bus showed in that cycle. Every comparison is thus made against the state built up by edges that have already happened.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int unsigned CMD_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_BOTH  = 2'b11
  } pbus_op_e;

  // Both command lines are active low: a line at 0 asserts its command.
  function automatic pbus_op_e decode_cmd(input logic rd_line, input logic wr_line);
    return pbus_op_e'({~wr_line, ~rd_line});
  endfunction

  function automatic logic op_reads(input pbus_op_e op);
    return op[0];
  endfunction

  function automatic logic op_writes(input pbus_op_e op);
    return op[1];
  endfunction

  // One line of the wired-AND: high unless precharge is off and someone sinks it.
  function automatic logic line_level(input logic pch, input logic pull_a, input logic pull_b);
    return pch | ~(pull_a | pull_b);
  endfunction

  // Data line pull for one stored bit: sink the line when the bit is 0.
  function automatic logic bit_pull(input logic active, input logic stored);
    return active & ~stored;
  endfunction

endpackage

// File: rtl/pbus_wired_and.sv
module pbus_wired_and
  import pbus_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         precharge,
  input  logic [W-1:0] pull_a,
  input  logic [W-1:0] pull_b,
  output logic [W-1:0] level
);

  for (genvar i = 0; i < W; i++) begin : g_line
    assign level[i] = line_level(precharge, pull_a[i], pull_b[i]);
  end

endmodule

// File: rtl/pbus_sense.sv
module pbus_sense
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BUS_W = DATA_W + ADDR_W + CMD_W,
  localparam int unsigned RD_IDX = DATA_W + ADDR_W,
  localparam int unsigned WR_IDX = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              precharge,
  input  logic [BUS_W-1:0]  level,
  output logic              rd_lat,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              wr_now,
  output logic [ADDR_W-1:0] addr_now,
  output logic [DATA_W-1:0] data_now,
  output logic              reeval
);

  pbus_op_e    op_now;
  logic        rd_now;

  assign op_now   = decode_cmd(level[RD_IDX], level[WR_IDX]);
  assign rd_now   = ~precharge & op_reads(op_now);
  assign wr_now   = ~precharge & op_writes(op_now);
  assign addr_now = level[RD_IDX-1:DATA_W];
  assign data_now = level[DATA_W-1:0];

  // The output must be re-evaluated when the read state flips, or when a
  // read continues at a new address.
  assign reeval = ~precharge &
                  ((rd_now != rd_lat) || (rd_now && (addr_now != addr_lat)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_lat   <= 1'b0;
      addr_lat <= '0;
    end else if (!precharge) begin
      rd_lat   <= rd_now;
      addr_lat <= addr_now;
    end
  end

endmodule

// File: rtl/pbus_store.sv
module pbus_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)   words[w] <= '0;
      else if (hit) words[w] <= wr_data;
    end
  end

  assign rd_word = words[rd_addr];

endmodule

// File: rtl/pbus_pull_drv.sv
module pbus_pull_drv
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              precharge,
  input  logic              rd_lat,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] pull
);

  logic active;
  assign active = rd_lat & ~precharge;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign pull[b] = bit_pull(active, rd_word[b]);
  end

endmodule

// File: rtl/pbus_mem_slave.sv
module pbus_mem_slave
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BUS_W = DATA_W + ADDR_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              precharge,
  input  logic [BUS_W-1:0]  master_pull,
  output logic [BUS_W-1:0]  bus_level,
  output logic [DATA_W-1:0] mem_pull
);

  logic              rd_lat;
  logic [ADDR_W-1:0] addr_lat;
  logic              wr_now;
  logic [ADDR_W-1:0] addr_now;
  logic [DATA_W-1:0] data_now;
  logic              reeval;
  logic [DATA_W-1:0] rd_word;
  logic [BUS_W-1:0]  slave_pull;

  // The slave only ever sinks data lines.
  assign slave_pull = {{(BUS_W-DATA_W){1'b0}}, mem_pull};

  pbus_wired_and #(.W(BUS_W)) u_bus (
    .precharge (precharge),
    .pull_a    (master_pull),
    .pull_b    (slave_pull),
    .level     (bus_level)
  );

  pbus_sense #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .precharge (precharge),
    .level     (bus_level),
    .rd_lat    (rd_lat),
    .addr_lat  (addr_lat),
    .wr_now    (wr_now),
    .addr_now  (addr_now),
    .data_now  (data_now),
    .reeval    (reeval)
  );

  pbus_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_now),
    .wr_addr (addr_now),
    .wr_data (data_now),
    .rd_addr (addr_lat),
    .rd_word (rd_word)
  );

  pbus_pull_drv #(.DATA_W(DATA_W)) u_drv (
    .precharge (precharge),
    .rd_lat    (rd_lat),
    .rd_word   (rd_word),
    .pull      (mem_pull)
  );

endmodule

// File: rtl/pbus_mem_slave_chk.sv
module pbus_mem_slave_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BUS_W = DATA_W + ADDR_W + 2,
  localparam int unsigned RD_IDX = DATA_W + ADDR_W,
  localparam int unsigned WR_IDX = DATA_W + ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              precharge,
  input logic [BUS_W-1:0]  master_pull,
  input logic [BUS_W-1:0]  bus_level,
  input logic [DATA_W-1:0] mem_pull,
  input logic              rd_lat,
  input logic [ADDR_W-1:0] addr_lat,
  input logic              wr_now,
  input logic              reeval
);

  AST_PRECHARGE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> (bus_level == {BUS_W{1'b1}})); // R2

  AST_CTRL_LINES_FROM_MASTERS: assert property (@(posedge clk) disable iff (!rst_n)
    !precharge |-> (bus_level[BUS_W-1:DATA_W] == ~master_pull[BUS_W-1:DATA_W])); // R3

  AST_NO_SINK_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> (mem_pull == '0)); // R7

  AST_READ_LATCH_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !precharge |=> (rd_lat == !$past(bus_level[RD_IDX]))); // R4

  AST_PRECHARGE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |=> ($stable(rd_lat) && $stable(addr_lat))); // R8

  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!precharge && bus_level[RD_IDX] && bus_level[WR_IDX]) |=> (precharge || mem_pull == '0)); // R9

  AST_OUTPUT_STEADY_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!precharge && !reeval && !wr_now) |=> (precharge || $stable(mem_pull))); // R6

endmodule

bind pbus_mem_slave pbus_mem_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .precharge   (precharge),
  .master_pull (master_pull),
  .bus_level   (bus_level),
  .mem_pull    (mem_pull),
  .rd_lat      (rd_lat),
  .addr_lat    (addr_lat),
  .wr_now      (wr_now),
  .reeval      (reeval)
);

// File: tb/pbus_mem_slave_bench.sv
module pbus_mem_slave_bench;

  localparam int DW = 8;
  localparam int AW = 2;
  localparam int BW = 12;
  localparam int RDI = 10;
  localparam int WRI = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          precharge = 1'b1;
  logic [BW-1:0] master_pull = '0;
  logic [BW-1:0] bus_level;
  logic [DW-1:0] mem_pull;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench mirror of the slave.
  logic [DW-1:0] m_mem [4];
  logic          m_rd;
  logic [AW-1:0] m_addr;

  always #10 clk = ~clk;

  pbus_mem_slave u_pbus_mem_slave (
    .clk(clk), .rst_n(rst_n), .precharge(precharge),
    .master_pull(master_pull), .bus_level(bus_level), .mem_pull(mem_pull)
  );

  function automatic logic [DW-1:0] want_pull(logic pch);
    return (m_rd && !pch) ? ~m_mem[m_addr] : '0;
  endfunction

  function automatic logic [BW-1:0] want_bus(logic pch, logic [BW-1:0] mp, logic [DW-1:0] sp);
    logic [BW-1:0] r;
    r = ~(mp | {4'b0, sp});
    return pch ? '1 : r;
  endfunction

  function automatic logic [BW-1:0] cmd_pull(logic rd, logic wr, logic [AW-1:0] a, logic [DW-1:0] dpull);
    logic [BW-1:0] p;
    p = '0;
    p[RDI] = rd;
    p[WRI] = wr;
    p[9:8] = ~a;
    p[DW-1:0] = dpull;
    return p;
  endfunction

  task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare mid low phase,
  // then advance the mirror with what the coming rising edge will sense.
  task automatic step(logic pch, logic [BW-1:0] mp, string tag);
    logic [DW-1:0] ep;
    logic [BW-1:0] eb;
    @(negedge clk);
    precharge = pch;
    master_pull = mp;
    #5;
    ep = want_pull(pch);
    eb = want_bus(pch, mp, ep);
    chk({tag, " pull"}, {4'b0, mem_pull}, {4'b0, ep});
    chk({tag, " bus"}, bus_level, eb);
    if (!pch) begin
      if (!eb[WRI]) m_mem[eb[9:8]] = eb[DW-1:0];
      m_rd = !eb[RDI];
      m_addr = eb[9:8];
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    step(1'b0, cmd_pull(1'b0, 1'b1, a, ~d), "R5 write");
  endtask

  task automatic rd(logic [AW-1:0] a);
    step(1'b0, cmd_pull(1'b1, 1'b0, a, '0), "R4 read cmd");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    void'($urandom(32'd7));
    for (int i = 0; i < 4; i++) m_mem[i] = '0;
    m_rd = 0;
    m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all words read back 0.
    step(1'b0, '0, "R1 reset");
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a));
      step(1'b0, '0, "R1 zero word");
      chk("R1 zero data", {4'b0, bus_level[DW-1:0]}, 12'h000);
    end

    // R5/R6: write then read back through the bus.
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h3C);
    step(1'b0, '0, "R9 idle");
    rd(2'd1);
    step(1'b0, '0, "R6 read data");
    chk("R6 readback A5", {4'b0, bus_level[DW-1:0]}, 12'h0A5);

    // R2/R7/R8: precharge between command and data holds the read.
    rd(2'd2);
    step(1'b1, '1, "R2 precharge all pulled");
    step(1'b1, cmd_pull(1'b1, 1'b1, 2'd0, 8'hFF), "R8 ignored write");
    step(1'b0, '0, "R8 held read");
    chk("R8 readback 3C", {4'b0, bus_level[DW-1:0]}, 12'h03C);
    rd(2'd0);
    step(1'b0, '0, "R8 word0 untouched");
    chk("R8 word0 still 0", {4'b0, bus_level[DW-1:0]}, 12'h000);

    // R9: idle releases the data lines.
    step(1'b0, '0, "R9 idle released");
    chk("R9 no pull", {4'b0, mem_pull}, 12'h000);

    // R6: read and write together on the same address, then all ones / zeros.
    step(1'b0, cmd_pull(1'b1, 1'b1, 2'd3, 8'h0F), "R6 both cmds");
    step(1'b0, '0, "R6 both result");
    chk("R6 both stored", {4'b0, bus_level[DW-1:0]}, 12'h0F0);
    wr(2'd3, 8'hFF);
    rd(2'd3);
    step(1'b0, '0, "R6 all ones");
    wr(2'd3, 8'h00);
    rd(2'd3);
    step(1'b0, '0, "R6 all zeros");

    // R3: a master pulling data lines during a read combines with the slave.
    rd(2'd1);
    step(1'b0, {4'b0, 8'h0F}, "R3 wired and");

    // Constrained random traffic.
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic pch;
      logic [AW-1:0] a;
      pch = ($urandom % 4) == 0;
      op = $urandom % 8;
      a = AW'($urandom);
      v = DW'($urandom);
      if (op < 3)      step(pch, cmd_pull(1'b0, 1'b1, a, ~v), "R5 rand write");
      else if (op < 6) step(pch, cmd_pull(1'b1, 1'b0, a, '0), "R6 rand read");
      else if (op < 7) step(pch, '0, "R9 rand idle");
      else             step(pch, BW'($urandom), "R3 rand noise");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule